// File: doc/BRIEF.md
# Secondary Bus Reset Controller

This block produces the active-low reset pin that a bus bridge drives onto its secondary bus. Five sources can request that reset: the bridge's own primary reset input, a reset input arriving from the secondary side, a configuration write to a secondary-reset control bit, a configuration write to a chip-reset control bit, and a power-state wake event (D3hot to D0). Every source pulls the pin low. The sources differ in how the pin is released.

The two reset inputs are level-following, so the pin is released when the input is released. A software write of the control bit holds the pin until software writes the bit back to zero. The chip-reset and power-wake events set the control bit by themselves, start a timer, and clear the bit again when the timer expires. The timer's default length is a little over 100 ms at a 100 MHz clock.

Alongside the pin, the block drives two internal reset levels. One clears the bridge's data buffers. The other clears its register state. A reset requested only through the software control bit clears the buffers and leaves the registers alone. The asynchronous inputs are brought into the clock domain through two-flop synchronizers. The primary reset input also forces every output immediately, without waiting for a clock.

Top module: `sec_bus_reset`

## Requirements
- R1: While `priRstN` is low, the outputs are forced at once, without waiting for a clock edge, to `secRstOutN`=0, `bufRst`=1, `stateRst`=1 and `secRstBit`=0.
- R2: When `priRstN` rises at a clock edge and no other source is active, the outputs are released after the second rising clock edge that samples it high. `secRstBit` stays 0 throughout.
- R3: The secondary reset input `secRstInN` is synchronized through two flops.
  - After it has been sampled low at two successive edges, the block holds `secRstOutN`=0, `bufRst`=1 and `stateRst`=1.
  - After it has been sampled high at two successive edges, the block releases those outputs.
  - `secRstBit` is never set by this source.
- R4: A configuration write (`cfgWrEn`=1) with `cfgWrBit`=1 sets `secRstBit` at the next edge.
  - While the bit is set, `secRstOutN`=0 and `bufRst`=1, but `stateRst` stays 0.
  - The bit holds with no timeout until a configuration write with `cfgWrBit`=0 clears it.
- R5: A one-cycle `chipRstWr` pulse sets `secRstBit` and asserts `stateRst`, `bufRst` and the pin for exactly `AUTO_CYCLES` cycles. After that the bit clears by itself.
- R6: A one-cycle `pmD3ToD0` pulse has the same timed effect as R5.
- R7: A `chipRstWr` or `pmD3ToD0` pulse that arrives while the timer runs restarts the count. The bit then stays set for `AUTO_CYCLES` cycles after the later pulse.
- R8: Configuration writes are ignored in two cases: while a timed pulse is running, and while the synchronized primary reset is still active.
- R9: The pin is the OR of all active conditions. A secondary reset input that is still low when the timer expires keeps `secRstOutN` low and `stateRst` high, while `secRstBit` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| priRstN | input | 1 | Primary reset, active low, asynchronous |
| secRstInN | input | 1 | Secondary-side reset input, active low, asynchronous |
| cfgWrEn | input | 1 | Configuration write strobe for the secondary reset bit |
| cfgWrBit | input | 1 | Value written to the secondary reset bit |
| chipRstWr | input | 1 | One-cycle pulse: software set the chip reset bit |
| pmD3ToD0 | input | 1 | One-cycle pulse: power state moved from D3hot to D0 |
| secRstOutN | output | 1 | Secondary bus reset pin, active low |
| bufRst | output | 1 | Data buffer reset level, active high |
| stateRst | output | 1 | Register state reset level, active high |
| secRstBit | output | 1 | Current value of the secondary reset control bit |

## Verification
The bench drives each source on its own first. That separates the level-following release of the two inputs from the write-cleared release and from the timed release, and it shows which of the two internal resets each source raises. It then overlaps the sources in three ways:
- a second timed trigger inside a running pulse, to show the count restarts;
- a configuration write during a timed pulse and during primary reset synchronization, to show the write is ignored;
- a secondary input held low past the timer's expiry, to show the pin is an OR of the conditions rather than a single owner.

A primary reset dropped in the middle of a clock cycle shows that it forces the outputs asynchronously.

// File: rtl/sec_bus_reset_pkg.sv
package sec_bus_reset_pkg;
  // strobes from the control half to the timer/output half
  typedef struct packed {
    logic timerStart;   // load the release timer with zero
    logic timerRun;     // a timed pulse is in progress
  } tmrCtl_t;
endpackage

// File: rtl/sec_bus_reset_sync.sv
module sec_bus_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) stg <= '0;
        else        stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sec_bus_reset_ctrl.sv
module sec_bus_reset_ctrl
  import sec_bus_reset_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    priOk,
  input  logic    cfgWrEn,
  input  logic    cfgWrBit,
  input  logic    chipRstWr,
  input  logic    pmD3ToD0,
  input  logic    timerDone,
  output logic    secBit,
  output logic    autoOn,
  output tmrCtl_t ctl
);
  logic autoTrig;
  logic secBitNxt, autoOnNxt;

  assign autoTrig = priOk && (chipRstWr || pmD3ToD0);

  always_comb begin
    secBitNxt = secBit;
    autoOnNxt = autoOn;
    if (!priOk) begin
      secBitNxt = 1'b0;
      autoOnNxt = 1'b0;
    end else if (autoTrig) begin
      secBitNxt = 1'b1;
      autoOnNxt = 1'b1;
    end else if (autoOn) begin
      if (timerDone) begin
        secBitNxt = 1'b0;
        autoOnNxt = 1'b0;
      end
    end else if (cfgWrEn) begin
      secBitNxt = cfgWrBit;
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      secBit <= 1'b0;
      autoOn <= 1'b0;
    end else begin
      secBit <= secBitNxt;
      autoOn <= autoOnNxt;
    end
  end

  assign ctl.timerStart = autoTrig;
  assign ctl.timerRun   = autoOn;
endmodule

// File: rtl/sec_bus_reset_dp.sv
module sec_bus_reset_dp
  import sec_bus_reset_pkg::*;
#(
  parameter int AUTO_CYCLES = 10_100_000
) (
  input  logic    clk,
  input  logic    arstN,
  input  logic    priOk,
  input  logic    secOk,
  input  logic    secBit,
  input  logic    autoOn,
  input  tmrCtl_t ctl,
  output logic    timerDone,
  output logic    secRstOutN,
  output logic    bufRst,
  output logic    stateRst
);
  localparam int CNT_W = (AUTO_CYCLES > 2) ? $clog2(AUTO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AUTO_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic hwHold;

  assign timerDone = ctl.timerRun && (cnt == LAST);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                          cnt <= '0;
    else if (!priOk || ctl.timerStart)   cnt <= '0;
    else if (ctl.timerRun && !timerDone) cnt <= cnt + 1'b1;
  end

  // every term below comes straight from a flop
  assign hwHold     = !priOk || !secOk;
  assign bufRst     = hwHold || secBit;
  assign stateRst   = hwHold || autoOn;
  assign secRstOutN = !bufRst;
endmodule

// File: rtl/sec_bus_reset.sv
module sec_bus_reset
  import sec_bus_reset_pkg::*;
#(
  parameter int AUTO_CYCLES = 10_100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic priRstN,
  input  logic secRstInN,
  input  logic cfgWrEn,
  input  logic cfgWrBit,
  input  logic chipRstWr,
  input  logic pmD3ToD0,
  output logic secRstOutN,
  output logic bufRst,
  output logic stateRst,
  output logic secRstBit
);
  logic priOk, secOk, autoOn, timerDone;
  tmrCtl_t ctl;

  sec_bus_reset_sync #(.STAGES(SYNC_STAGES)) u_priSync (
    .clk(clk), .arstN(priRstN), .din(1'b1), .dout(priOk));

  sec_bus_reset_sync #(.STAGES(SYNC_STAGES)) u_secSync (
    .clk(clk), .arstN(priRstN), .din(secRstInN), .dout(secOk));

  sec_bus_reset_ctrl u_ctrl (
    .clk(clk), .arstN(priRstN), .priOk(priOk),
    .cfgWrEn(cfgWrEn), .cfgWrBit(cfgWrBit),
    .chipRstWr(chipRstWr), .pmD3ToD0(pmD3ToD0),
    .timerDone(timerDone), .secBit(secRstBit), .autoOn(autoOn), .ctl(ctl));

  sec_bus_reset_dp #(.AUTO_CYCLES(AUTO_CYCLES)) u_dp (
    .clk(clk), .arstN(priRstN), .priOk(priOk), .secOk(secOk),
    .secBit(secRstBit), .autoOn(autoOn), .ctl(ctl),
    .timerDone(timerDone), .secRstOutN(secRstOutN),
    .bufRst(bufRst), .stateRst(stateRst));
endmodule

// File: rtl/sec_bus_reset_chk.sv
module sec_bus_reset_chk (
  input logic clk,
  input logic priRstN,
  input logic secRstInN,
  input logic cfgWrEn,
  input logic chipRstWr,
  input logic pmD3ToD0,
  input logic secRstOutN,
  input logic bufRst,
  input logic stateRst,
  input logic secRstBit
);
  AST_PRI_FORCES_ALL: assert property (@(posedge clk)
    !priRstN |-> (!secRstOutN && bufRst && stateRst && !secRstBit)); // R1

  AST_SECIN_HOLDS: assert property (@(posedge clk) disable iff (!priRstN)
    (!secRstInN && $past(!secRstInN)) |=> (!secRstOutN && stateRst)); // R3

  AST_MANUAL_BIT_STICKS: assert property (@(posedge clk) disable iff (!priRstN)
    (secRstBit && !stateRst && !cfgWrEn && !chipRstWr && !pmD3ToD0) |=> secRstBit); // R4

  AST_AUTO_TRIGGER: assert property (@(posedge clk) disable iff (!priRstN)
    ((chipRstWr || pmD3ToD0) && !stateRst) |=> (secRstBit && stateRst)); // R5

  AST_BIT_DRIVES_PIN: assert property (@(posedge clk) disable iff (!priRstN)
    secRstBit |-> (!secRstOutN && bufRst)); // R9
endmodule

bind sec_bus_reset sec_bus_reset_chk u_chk (.*);

// File: tb/sim_sec_bus_reset.sv
module sim_sec_bus_reset;
  localparam int CLK_PERIOD = 10;
  localparam int AUTO = 20;

  logic clk = 1'b0;
  logic priRstN = 1'b1, secRstInN = 1'b1, cfgWrEn = 1'b0, cfgWrBit = 1'b0;
  logic chipRstWr = 1'b0, pmD3ToD0 = 1'b0;
  logic secRstOutN, bufRst, stateRst, secRstBit;

  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit finished = 0;

  // reference model state
  int  mPriCnt = 0;
  bit  secHist[$] = '{1'b0, 1'b0};
  bit  mBit = 0, mAuto = 0;
  int  mLeft = 0;

  sec_bus_reset #(.AUTO_CYCLES(AUTO)) u0 (
    .clk(clk), .priRstN(priRstN), .secRstInN(secRstInN),
    .cfgWrEn(cfgWrEn), .cfgWrBit(cfgWrBit), .chipRstWr(chipRstWr),
    .pmD3ToD0(pmD3ToD0), .secRstOutN(secRstOutN), .bufRst(bufRst),
    .stateRst(stateRst), .secRstBit(secRstBit));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit priOkOld, eOut, eState, hw;
    priOkOld = (mPriCnt >= 2);
    if (!priRstN) begin
      mPriCnt = 0; secHist = '{1'b0, 1'b0}; mBit = 0; mAuto = 0; mLeft = 0;
    end else begin
      if (priOkOld) begin
        if (chipRstWr || pmD3ToD0) begin
          mBit = 1; mAuto = 1; mLeft = AUTO;
        end else if (mAuto) begin
          mLeft--;
          if (mLeft == 0) begin mBit = 0; mAuto = 0; end
        end else if (cfgWrEn) mBit = cfgWrBit;
      end
      if (mPriCnt < 2) mPriCnt++;
      secHist.push_back(secRstInN);
      void'(secHist.pop_front());
    end
    hw = (mPriCnt < 2) || !secHist[0];
    eOut = !(hw || mBit);
    eState = hw || mAuto;
    #1;
    chk(curReq, "secRstOutN", secRstOutN, eOut);
    chk(curReq, "bufRst", bufRst, !eOut);
    chk(curReq, "stateRst", stateRst, eState);
    chk(curReq, "secRstBit", secRstBit, mBit);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic cfgWrite(input logic v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrBit = v;
    @(negedge clk); cfgWrEn = 1'b0; cfgWrBit = 1'b0;
  endtask

  task automatic measureBit(input string req);
    int n = 0;
    while (secRstBit === 1'b1 && n < 4*AUTO) begin
      n++;
      @(negedge clk);
    end
    chk(req, "timed pulse length", (n == AUTO), 1'b1);
  endtask

  initial begin
    #2 priRstN = 1'b0;
    curReq = "R1";
    idle(4);
    chk("R1", "secRstOutN in reset", secRstOutN, 1'b0);
    curReq = "R2";
    priRstN = 1'b1;
    idle(5);
    chk("R2", "released pin", secRstOutN, 1'b1);

    curReq = "R3";
    @(negedge clk); secRstInN = 1'b0;
    idle(6);
    chk("R3", "bit untouched by sec input", secRstBit, 1'b0);
    secRstInN = 1'b1;
    idle(4);

    curReq = "R4";
    cfgWrite(1'b1);
    idle(3 * AUTO);
    chk("R4", "bit holds without timeout", secRstBit, 1'b1);
    chk("R4", "state kept", stateRst, 1'b0);
    cfgWrite(1'b0);
    idle(3);

    curReq = "R5";
    pulse(chipRstWr);
    measureBit("R5");
    idle(3);

    curReq = "R6";
    pulse(pmD3ToD0);
    measureBit("R6");
    idle(3);

    curReq = "R7";
    pulse(chipRstWr);
    idle(8);
    pulse(pmD3ToD0);
    measureBit("R7");
    idle(3);

    curReq = "R8";
    pulse(chipRstWr);
    idle(3);
    cfgWrite(1'b0);
    chk("R8", "write ignored during pulse", secRstBit, 1'b1);
    idle(AUTO + 3);
    @(negedge clk); priRstN = 1'b0;
    @(negedge clk); priRstN = 1'b1; cfgWrEn = 1'b1; cfgWrBit = 1'b1;
    @(negedge clk); cfgWrEn = 1'b0; cfgWrBit = 1'b0;
    idle(3);
    chk("R8", "write ignored during primary sync", secRstBit, 1'b0);

    curReq = "R9";
    pulse(chipRstWr);
    secRstInN = 1'b0;
    idle(AUTO + 6);
    chk("R9", "bit cleared", secRstBit, 1'b0);
    chk("R9", "pin still held", secRstOutN, 1'b0);
    secRstInN = 1'b1;
    idle(5);

    curReq = "R1";
    cfgWrite(1'b1);
    idle(2);
    #2 priRstN = 1'b0;
    #1;
    chk("R1", "async bit clear", secRstBit, 1'b0);
    chk("R1", "async state reset", stateRst, 1'b1);
    idle(2);
    priRstN = 1'b1;
    idle(5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule